// File: doc/BRIEF.md
# Retriggerable Extended Pulse Timer

This block produces a timed pulse in the manner of a programmable-logic-controller timer. A rising edge on the start input loads a preset into a remaining-time counter and raises the pulse output. The counter then drops by one on every tick-enable pulse from an external time-base prescaler, and the pulse ends when the counter reaches zero.

Letting the start input fall does not shorten the pulse. A fresh rising edge on start during the pulse reloads the full preset. A rising edge on the reset input during the pulse ends it at once. The remaining time is shown in two forms: as a plain binary count and as packed BCD digits that a display or a reporting path can use directly.

Top module: `pulse_timer`

## Requirements
- R1: A 0-to-1 transition of startIn, sampled on the rising clock edge, starts the timer. A startIn held high never starts the timer a second time once the pulse has ended.
- R2: Once started with preset P, the timer runs for exactly P tick-enable pulses. Whether startIn stays high or returns to 0 has no effect on this.
- R3: qOut is 1 exactly when the remaining count is nonzero and 0 otherwise.
- R4: A startIn rising edge while the timer runs reloads the full preset. When it falls in the same cycle as a tick, the reload wins and the tick is dropped.
- R5: A resetIn rising edge while the timer runs clears the count to 0 and drops qOut. This takes priority over a start edge in the same cycle. A resetIn held high does not block a later start edge. A resetIn edge while idle has no effect.
- R6: remainBin equals the preset minus the ticks seen since the last start. It falls by one per tickEn cycle while running and stays at 0 when idle, even with ticks.
- R7: remainBcd shows remainBin in decimal. Bits [3:0] hold the units, [7:4] the tens and [11:8] the hundreds, and each digit is in 0..9.
- R8: A preset of 0 gives no pulse. A preset above 999 is treated as 999.
- R9: While the synchronous reset rst is high, qOut, remainBin and remainBcd are 0 and the stored start and reset history is cleared to 0. As a result, a startIn held high through the release of rst starts the timer on the first clock after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | One-cycle time-base pulse that advances the countdown |
| startIn | input | 1 | Start request; acts on its rising edge |
| resetIn | input | 1 | Stop request; acts on its rising edge while running |
| presetIn | input | 10 | Pulse length in ticks (0..999; larger values treated as 999) |
| qOut | output | 1 | Pulse output, high while the timer runs |
| remainBin | output | 10 | Remaining ticks, binary |
| remainBcd | output | 12 | Remaining ticks, three packed BCD digits |

## Verification
A corrupted edge register shows up at qOut one cycle after the offending input change. A level may then start or clear the pulse, or a genuine edge may be missed. A wrong counter value appears on remainBin and remainBcd in the very next cycle, because both outputs are taken straight from the count. A counter that is off by one makes qOut fall one tick early or late, which shows up when the pulse length is measured against the preset. A fault in the decimal conversion affects only remainBcd, and it appears at once for the values whose digits cross a carry boundary. The bench therefore sweeps every preset code through the conversion.

// File: rtl/pulse_timer_pkg.sv
package pulse_timer_pkg;

  // Strobes from control to datapath; at most one is high per cycle.
  typedef struct packed {
    logic load;   // take the (clamped) preset into the counter
    logic dec;    // count down by one
    logic clear;  // force the counter to zero
  } tmrStrobe_t;

endpackage

// File: rtl/pulse_timer_bcd.sv
module pulse_timer_bcd #(
  parameter int BIN_W  = 10,
  parameter int DIGITS = 3
) (
  input  logic [BIN_W-1:0]    binIn,
  output logic [4*DIGITS-1:0] bcdOut
);

  localparam int BCD_W = 4 * DIGITS;

  logic [BCD_W-1:0] work;

  // Shift-and-add-three conversion, fully unrolled.
  always_comb begin
    work = '0;
    for (int i = BIN_W - 1; i >= 0; i--) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (work[4*d +: 4] >= 4'd5) begin
          work[4*d +: 4] = work[4*d +: 4] + 4'd3;
        end
      end
      work = {work[BCD_W-2:0], binIn[i]};
    end
  end

  assign bcdOut = work;

endmodule

// File: rtl/pulse_timer_ctrl.sv
module pulse_timer_ctrl
  import pulse_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tickEn,
  input  logic       startIn,
  input  logic       resetIn,
  input  logic       lastCount,
  input  logic       presetZero,
  output tmrStrobe_t strobe,
  output logic       running
);

  logic startPrev;
  logic resetPrev;
  logic startRise;
  logic resetRise;
  logic runNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      startPrev <= 1'b0;
      resetPrev <= 1'b0;
    end else begin
      startPrev <= startIn;
      resetPrev <= resetIn;
    end
  end

  assign startRise = startIn & ~startPrev;
  assign resetRise = resetIn & ~resetPrev;

  // Priority: reset edge while running, then start edge, then tick.
  always_comb begin
    strobe = '0;
    if (running && resetRise) begin
      strobe.clear = 1'b1;
    end else if (startRise) begin
      strobe.load = 1'b1;
    end else if (running && tickEn) begin
      strobe.dec = 1'b1;
    end
  end

  always_comb begin
    runNext = running;
    if (strobe.clear) begin
      runNext = 1'b0;
    end else if (strobe.load) begin
      runNext = ~presetZero;
    end else if (strobe.dec) begin
      runNext = ~lastCount;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
    end else begin
      running <= runNext;
    end
  end

  // R1: an idle timer without a start edge stays idle
  p_level_no_start_r1: assert property (@(posedge clk) disable iff (rst)
    (!running && !(startIn && !startPrev)) |=> !running);

  // R1: a start edge with a nonzero preset and no stop makes it run
  p_edge_starts_r1: assert property (@(posedge clk) disable iff (rst)
    (startIn && !startPrev && !presetZero && !(running && resetIn && !resetPrev)) |=> running);

  // R5: a reset edge while running stops the pulse
  p_reset_stops_r5: assert property (@(posedge clk) disable iff (rst)
    (running && resetIn && !resetPrev) |=> !running);

  // R8: a zero preset on a start edge produces no pulse
  p_zero_preset_r8: assert property (@(posedge clk) disable iff (rst)
    (startIn && !startPrev && presetZero) |=> !running);

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.load, strobe.dec, strobe.clear}));

endmodule

// File: rtl/pulse_timer_dp.sv
module pulse_timer_dp
  import pulse_timer_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int DIGITS     = 3,
  parameter int MAX_PRESET = 999
) (
  input  logic                clk,
  input  logic                rst,
  input  tmrStrobe_t          strobe,
  input  logic [CNT_W-1:0]    presetIn,
  output logic [CNT_W-1:0]    count,
  output logic [4*DIGITS-1:0] bcd,
  output logic                lastCount,
  output logic                presetZero
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_PRESET);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  logic [CNT_W-1:0] presetEff;

  assign presetEff  = (presetIn > MAX_CNT) ? MAX_CNT : presetIn;
  assign presetZero = (presetEff == '0);
  assign lastCount  = (count == ONE_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (strobe.clear) begin
      count <= '0;
    end else if (strobe.load) begin
      count <= presetEff;
    end else if (strobe.dec) begin
      count <= count - ONE_CNT;
    end
  end

  pulse_timer_bcd #(
    .BIN_W (CNT_W),
    .DIGITS(DIGITS)
  ) u_bcd (
    .binIn (count),
    .bcdOut(bcd)
  );

  // R6: a decrement lowers the count by exactly one
  p_dec_one_r6: assert property (@(posedge clk) disable iff (rst)
    strobe.dec |=> (count == $past(count) - ONE_CNT));

  // R6: with no strobe the count holds
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(strobe.dec || strobe.load || strobe.clear) |=> $stable(count));

  // R4: a load takes the full clamped preset
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (count == $past(presetEff)));

  // R5: a clear zeroes the count
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.clear |=> (count == '0));

  // R8: the count never exceeds the largest preset
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    count <= MAX_CNT);

  // R7: every BCD digit is decimal
  p_digit_range_r7: assert property (@(posedge clk) disable iff (rst)
    (bcd[3:0] <= 4'd9) && (bcd[7:4] <= 4'd9) && (bcd[11:8] <= 4'd9));

  // R7: digits weighted back equal the binary count
  p_bcd_value_r7: assert property (@(posedge clk) disable iff (rst)
    (32'(bcd[3:0]) + 32'(bcd[7:4]) * 10 + 32'(bcd[11:8]) * 100) == 32'(count));

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
  import pulse_timer_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int DIGITS     = 3,
  parameter int MAX_PRESET = 999
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tickEn,
  input  logic                startIn,
  input  logic                resetIn,
  input  logic [CNT_W-1:0]    presetIn,
  output logic                qOut,
  output logic [CNT_W-1:0]    remainBin,
  output logic [4*DIGITS-1:0] remainBcd
);

  tmrStrobe_t       strobe;
  logic             running;
  logic             lastCount;
  logic             presetZero;
  logic [CNT_W-1:0] count;

  pulse_timer_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tickEn    (tickEn),
    .startIn   (startIn),
    .resetIn   (resetIn),
    .lastCount (lastCount),
    .presetZero(presetZero),
    .strobe    (strobe),
    .running   (running)
  );

  pulse_timer_dp #(
    .CNT_W     (CNT_W),
    .DIGITS    (DIGITS),
    .MAX_PRESET(MAX_PRESET)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .presetIn  (presetIn),
    .count     (count),
    .bcd       (remainBcd),
    .lastCount (lastCount),
    .presetZero(presetZero)
  );

  assign qOut      = running;
  assign remainBin = count;

  // R3: control's run flag and datapath's count agree
  p_q_tracks_count_r3: assert property (@(posedge clk) disable iff (rst)
    qOut == (count != '0));

endmodule

// File: tb/pulse_timer_test.sv
`timescale 1ns/1ps
module pulse_timer_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        tickEn;
  logic        startIn;
  logic        resetIn;
  logic [9:0]  presetIn;
  logic        qOut;
  logic [9:0]  remainBin;
  logic [11:0] remainBcd;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pulse_timer uut (
    .clk      (clk),
    .rst      (rst),
    .tickEn   (tickEn),
    .startIn  (startIn),
    .resetIn  (resetIn),
    .presetIn (presetIn),
    .qOut     (qOut),
    .remainBin(remainBin),
    .remainBcd(remainBcd)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int toBcd(input int v);
    return ((v / 100) << 8) | (((v / 10) % 10) << 4) | (v % 10);
  endfunction

  // Drive at a falling edge; return at the next falling edge.
  task automatic step(input logic s, input logic r, input logic t);
    startIn = s;
    resetIn = r;
    tickEn  = t;
    @(negedge clk);
  endtask

  task automatic expectCount(input string req, input int v);
    check(req, int'(remainBin), v);
    check(req, int'(qOut), (v != 0) ? 1 : 0);
  endtask

  initial begin
    rst = 1'b1; tickEn = 1'b0; startIn = 1'b0; resetIn = 1'b0; presetIn = '0;
    repeat (3) @(negedge clk);
    check("R9 reset q", int'(qOut), 0);
    check("R9 reset bin", int'(remainBin), 0);
    check("R9 reset bcd", int'(remainBcd), 0);
    rst = 1'b0;
    step(0, 0, 0);

    // R7/R8: sweep every preset code through load and conversion; R5 stop each
    for (int p = 0; p < 1024; p++) begin
      int e;
      e = (p > 999) ? 999 : p;
      presetIn = 10'(p);
      step(0, 0, 0);
      step(1, 0, 0);
      check("R8 clamp bin", int'(remainBin), e);
      check("R7 bcd", int'(remainBcd), toBcd(e));
      check("R3 q", int'(qOut), (e != 0) ? 1 : 0);
      step(0, 1, 0);
      expectCount("R5 reset edge", 0);
      step(0, 0, 0);
    end

    // R2/R6: pulse length equals preset ticks, start released
    for (int p = 1; p <= 12; p++) begin
      presetIn = 10'(p);
      step(1, 0, 0);
      expectCount("R1 start", p);
      for (int k = 1; k <= p + 2; k++) begin
        step(0, 0, 1);
        expectCount("R2 R6 countdown", (k < p) ? p - k : 0);
      end
      step(0, 0, 0);
    end

    // R1: start held high does not restart after expiry
    presetIn = 10'd3;
    step(1, 0, 0);
    expectCount("R1 start", 3);
    for (int k = 1; k <= 6; k++) begin
      step(1, 0, 1);
      expectCount("R1 level no restart", (k < 3) ? 3 - k : 0);
    end
    step(0, 0, 0);

    // R4: retrigger reloads, wins over tick, level does not reload
    presetIn = 10'd10;
    step(1, 0, 0);
    step(0, 0, 1); step(0, 0, 1); step(0, 0, 1); step(0, 0, 1);
    expectCount("R6 after four ticks", 6);
    step(1, 0, 1);
    expectCount("R4 reload over tick", 10);
    check("R7 bcd ten", int'(remainBcd), 12'h010);
    step(1, 0, 1);
    expectCount("R4 level no reload", 9);
    step(0, 0, 0);
    step(0, 1, 0);
    step(0, 0, 0);

    // R5: priorities and levels of resetIn
    presetIn = 10'd7;
    step(1, 0, 0);
    expectCount("R1 start", 7);
    step(0, 0, 0);
    step(1, 1, 0);
    expectCount("R5 reset beats start", 0);
    step(0, 1, 0);
    step(1, 1, 0);
    expectCount("R5 held reset no block", 7);
    step(0, 0, 0);
    step(0, 1, 0);
    expectCount("R5 reset edge running", 0);
    step(0, 0, 0);
    step(0, 1, 0);
    expectCount("R5 idle reset edge", 0);
    step(1, 0, 0);
    expectCount("R5 start after idle reset", 7);
    step(0, 0, 1);
    expectCount("R6 tick", 6);
    step(0, 1, 0);
    step(0, 0, 1); step(0, 0, 1);
    expectCount("R6 idle ticks ignored", 0);
    step(0, 0, 0);

    // R8: zero preset gives no pulse even with ticks
    presetIn = 10'd0;
    step(1, 0, 1);
    expectCount("R8 zero preset", 0);
    step(0, 0, 0);

    // R9: start held through reset release
    presetIn = 10'd5;
    startIn = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    expectCount("R9 reset with start high", 0);
    rst = 1'b0;
    step(1, 0, 0);
    expectCount("R9 start after release", 5);
    check("R7 bcd five", int'(remainBcd), 12'h005);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule